// File: doc/BRIEF.md
# Keyed-Command Watchdog Timer

This block is a watchdog that software drives entirely through one 8-bit register port. Particular byte values act as commands: one restarts and enables the count, a two-byte pair turns the watchdog off, and another byte permanently blocks that turn-off path until the next system reset. Any write whose top bit is clear is not a command. It is an interval write, and its low three bits choose a timeout of 4^(3+N) system clocks.

Once enabled, a counter advances on every system clock. If the count reaches the selected timeout before software restarts it, the block raises its reset request for exactly one clock. The count then starts again from zero, so a watchdog that keeps being neglected produces one request per timeout period. A reset generator outside this block acts on the request. The register port has no handshake: a write takes effect on the clock edge where the strobe is high, and the read data is always valid.

Top module: `keywd_top`

## Requirements
- R1: After a synchronous reset the watchdog is enabled, its count is zero, the interval field is 111b, disabling is not locked out, no disable is pending, and `req_rst` is 0. A read then returns 0x17.
- R2: A write of 0xA5 enables the watchdog and restarts its count from zero on the same edge.
- R3: With interval N (0 to 7), `req_rst` rises exactly 4^(3+N) clock edges after the edge that restarted the count. For example, N=0 gives 64 edges and N=1 gives 256 edges.
- R4: `req_rst` stays high for one clock only. The count restarts at that edge, so with no further writes the next request follows one full timeout later.
- R5: A write of 0xDE followed by a write of 0xAD disables the watchdog when the 0xAD edge comes 1 to 4 edges after the 0xDE edge and disabling is not locked out. While disabled, read bit 4 is 0.
- R6: If 0xAD arrives 5 or more edges after 0xDE, or arrives with no 0xDE before it, it has no effect.
- R7: After 0xDE, any write other than 0xAD cancels the pending disable. That write is still decoded as its own command or interval write, and a following 0xAD is ignored.
- R8: A write of 0xFF locks out disabling until the next reset. It neither enables the watchdog nor restarts the count.
- R9: A write with bit 7 equal to 0 loads bits [2:0] into the interval field. A write with bit 7 equal to 1 never changes the interval field. Read bits [2:0] return the interval field.
- R10: Read bit 4 is 1 when the watchdog is enabled and 0 when it is disabled. Read bits 7, 6, 5 and 3 are always 0.
- R11: While the watchdog is disabled, the count holds at zero and `req_rst` stays 0. A later 0xA5 starts a full timeout from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the count advances once per rising edge |
| rst | input | 1 | Synchronous system reset, active high |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_data | input | 8 | Write byte: a command key, or an interval write when bit 7 is 0 |
| rd_data | output | 8 | Register read value: bit 4 is status, bits [2:0] are the interval |
| req_rst | output | 1 | One-clock reset request when the timeout expires |

## Verification
On every cycle, the embedded assertions check the following. A request never lasts two clocks, and none follows a disabled cycle. The enable bit falls only after a 0xAD write and rises only after a 0xA5 write. A lockout never lets the enable bit drop. The interval field moves only on writes with bit 7 clear. The count holds at zero while disabled. Other behaviours can only be shown by the bench's scenarios: the exact timeout lengths, the edge of the four-clock acceptance window, cancellation of a pending disable by an unrelated write, and the rule that a lockout write leaves a running count untouched.

// File: rtl/keywd_pkg.sv
package keywd_pkg;

  localparam logic [7:0] KEY_KICK  = 8'hA5;
  localparam logic [7:0] KEY_OFF_1 = 8'hDE;
  localparam logic [7:0] KEY_OFF_2 = 8'hAD;
  localparam logic [7:0] KEY_LOCK  = 8'hFF;

  // One decoded register write
  typedef struct packed {
    logic any;     // a write happened this cycle
    logic kick;    // enable and restart
    logic off_1;   // first byte of the disable pair
    logic off_2;   // second byte of the disable pair
    logic lock;    // lock out disabling
    logic ivl_wr;  // interval write (top bit clear)
  } wd_cmd_t;

endpackage

// File: rtl/keywd_decode.sv
module keywd_decode
  import keywd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IVL_W  = 3
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output wd_cmd_t           cmd,
  output logic [IVL_W-1:0]  ivl_val
);

  always_comb begin
    cmd        = '0;
    cmd.any    = wr_en;
    cmd.kick   = wr_en && (wr_data == KEY_KICK);
    cmd.off_1  = wr_en && (wr_data == KEY_OFF_1);
    cmd.off_2  = wr_en && (wr_data == KEY_OFF_2);
    cmd.lock   = wr_en && (wr_data == KEY_LOCK);
    cmd.ivl_wr = wr_en && !wr_data[DATA_W-1];
    ivl_val    = wr_data[IVL_W-1:0];
  end

endmodule

// File: rtl/keywd_arm.sv
module keywd_arm
  import keywd_pkg::*;
#(
  parameter int IVL_W = 3,
  parameter int WIN   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  wd_cmd_t          cmd,
  input  logic [IVL_W-1:0] ivl_val,
  output logic             enabled,
  output logic             locked,
  output logic [IVL_W-1:0] ivl
);

  localparam int AGE_W = $clog2(WIN + 1);

  logic             pend_q;
  logic [AGE_W-1:0] age_q;
  logic             off_ok;

  // second key accepted only inside the window and without lockout
  assign off_ok = pend_q && cmd.off_2 && !locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled <= 1'b1;
      locked  <= 1'b0;
      ivl     <= '1;
    end else begin
      if (cmd.ivl_wr) ivl <= ivl_val;
      if (cmd.lock)   locked <= 1'b1;
      if (cmd.kick)        enabled <= 1'b1;
      else if (off_ok)     enabled <= 1'b0;
    end
  end

  // pending-disable window: age counts edges since the first key
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      age_q  <= '0;
    end else if (cmd.off_1) begin
      pend_q <= 1'b1;
      age_q  <= AGE_W'(1);
    end else if (cmd.any) begin
      pend_q <= 1'b0;
      age_q  <= '0;
    end else if (pend_q) begin
      if (age_q == AGE_W'(WIN)) begin
        pend_q <= 1'b0;
        age_q  <= '0;
      end else begin
        age_q  <= age_q + AGE_W'(1);
      end
    end
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);  // R8
  AST_PEND_WINDOW: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> (age_q != '0) && (age_q <= AGE_W'(WIN)));  // R6

endmodule

// File: rtl/keywd_count.sv
module keywd_count #(
  parameter int CNT_W    = 21,
  parameter int IVL_W    = 3,
  parameter int BASE_EXP = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enabled,
  input  logic             kick,
  input  logic [IVL_W-1:0] ivl,
  output logic             expire
);

  localparam int MAX_SH = 2 * (BASE_EXP + (1 << IVL_W) - 1);
  localparam int SH_W   = $clog2(MAX_SH + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [SH_W-1:0]  shamt;
  logic [CNT_W-1:0] last;

  // limit = 4^(BASE_EXP+ivl); terminal count is limit-1
  always_comb begin
    shamt = SH_W'(2 * BASE_EXP) + SH_W'({ivl, 1'b0});
    last  = (CNT_W'(1) << shamt) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (kick || !enabled) begin
        cnt_q <= '0;
      end else if (cnt_q >= last) begin
        cnt_q  <= '0;
        expire <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_CNT_HELD: assert property (@(posedge clk) disable iff (rst)
    !enabled |=> (cnt_q == '0));  // R11
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);  // R4
  AST_REQ_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    expire |-> (cnt_q == '0));  // R4

endmodule

// File: rtl/keywd_top.sv
module keywd_top
  import keywd_pkg::*;
#(
  parameter int CNT_W    = 21,
  parameter int IVL_W    = 3,
  parameter int BASE_EXP = 3,
  parameter int WIN      = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       req_rst
);

  localparam int DATA_W   = 8;
  localparam int STAT_BIT = 4;

  wd_cmd_t          cmd;
  logic [IVL_W-1:0] ivl_val;
  logic             enabled;
  logic             locked;
  logic [IVL_W-1:0] ivl;

  keywd_decode #(.DATA_W(DATA_W), .IVL_W(IVL_W)) dec_i (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd     (cmd),
    .ivl_val (ivl_val)
  );

  keywd_arm #(.IVL_W(IVL_W), .WIN(WIN)) arm_i (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .ivl_val (ivl_val),
    .enabled (enabled),
    .locked  (locked),
    .ivl     (ivl)
  );

  keywd_count #(.CNT_W(CNT_W), .IVL_W(IVL_W), .BASE_EXP(BASE_EXP)) cnt_i (
    .clk     (clk),
    .rst     (rst),
    .enabled (enabled),
    .kick    (cmd.kick),
    .ivl     (ivl),
    .expire  (req_rst)
  );

  always_comb begin
    rd_data                = '0;
    rd_data[STAT_BIT]      = enabled;
    rd_data[IVL_W-1:0]     = ivl;
  end

  AST_DIS_KEYED: assert property (@(posedge clk) disable iff (rst)
    $fell(enabled) |-> $past(wr_en && (wr_data == KEY_OFF_2)));  // R5
  AST_EN_KEYED: assert property (@(posedge clk) disable iff (rst)
    $rose(enabled) |-> $past(wr_en && (wr_data == KEY_KICK)));  // R2
  AST_LOCK_NO_OFF: assert property (@(posedge clk) disable iff (rst)
    (locked && enabled) |=> enabled);  // R8
  AST_IVL_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !wr_data[DATA_W-1]) |=> $stable(ivl));  // R9
  AST_NO_REQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !enabled |=> !req_rst);  // R11

endmodule

// File: tb/keywd_tb.sv
module keywd_top_tb_top;

  localparam int CLK_P = 10;
  localparam int WD_CYC = 100000;
  localparam int NVEC = 28;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       req_rst;

  int checks = 0;
  int miscompares = 0;

  always #(CLK_P/2) clk = ~clk;

  keywd_top dut_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .req_rst (req_rst)
  );

  // {wr_en, wr_data, expected rd_data after the edge}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 8'h17},  // 0  reset state R1
    {1'b1, 8'h02, 8'h12},  // 1  interval write R9
    {1'b1, 8'h85, 8'h12},  // 2  top bit set, not a key: no change R9
    {1'b1, 8'h7D, 8'h15},  // 3  only low bits land R9 R10
    {1'b1, 8'h00, 8'h10},  // 4
    {1'b1, 8'hDE, 8'h10},  // 5  first key
    {1'b1, 8'hAD, 8'h00},  // 6  second key one edge later R5
    {1'b1, 8'h03, 8'h03},  // 7  interval while off R10
    {1'b1, 8'hA5, 8'h13},  // 8  re-enable R2
    {1'b1, 8'hDE, 8'h13},  // 9
    {1'b0, 8'h00, 8'h13},  // 10
    {1'b1, 8'h55, 8'h15},  // 11 other write cancels, still decoded R7
    {1'b1, 8'hAD, 8'h15},  // 12 second key ignored R7
    {1'b1, 8'hDE, 8'h15},  // 13
    {1'b0, 8'h00, 8'h15},  // 14
    {1'b0, 8'h00, 8'h15},  // 15
    {1'b0, 8'h00, 8'h15},  // 16
    {1'b1, 8'hAD, 8'h05},  // 17 four edges later: accepted R5
    {1'b1, 8'hA5, 8'h15},  // 18
    {1'b1, 8'hDE, 8'h15},  // 19
    {1'b0, 8'h00, 8'h15},  // 20
    {1'b0, 8'h00, 8'h15},  // 21
    {1'b0, 8'h00, 8'h15},  // 22
    {1'b0, 8'h00, 8'h15},  // 23
    {1'b1, 8'hAD, 8'h15},  // 24 five edges later: ignored R6
    {1'b1, 8'hFF, 8'h15},  // 25 lockout R8
    {1'b1, 8'hDE, 8'h15},  // 26
    {1'b1, 8'hAD, 8'h15}   // 27 locked: disable ignored R8
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // apply one cycle of input, sample a quarter period after the edge
  task automatic drive(input logic we, input logic [7:0] d);
    @(negedge clk);
    wr_en   = we;
    wr_data = d;
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst   = 1'b1;
    wr_en = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #(CLK_P/4);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // idle until req_rst; n counts edges since the restart edge
  task automatic wait_req(input int start, input int cap, output int n);
    n = start;
    for (int i = 0; i < cap; i++) begin
      drive(1'b0, 8'h00);
      n++;
      if (req_rst) break;
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    miscompares++;
    $display("FAIL R3 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, miscompares);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    #(CLK_P/4);
    chk("R1 reset rd_data", 32'(rd_data), 32'h17);
    chk("R1 reset req_rst", 32'(req_rst), 32'h0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][16], VEC[v][15:8]);
      chk($sformatf("table row %0d rd_data (R2 R5 R6 R7 R8 R9 R10)", v),
          32'(rd_data), 32'(VEC[v][7:0]));
      chk($sformatf("table row %0d req_rst", v), 32'(req_rst), 32'h0);
    end
    drive(1'b0, 8'h00);

    // R3 and R4: interval 0 timeout and re-arm
    do_reset();
    drive(1'b1, 8'h00);
    drive(1'b1, 8'hA5);
    wait_req(0, 100, n);
    chk("R3 interval 0 edges", 32'(n), 32'd64);
    drive(1'b0, 8'h00);
    chk("R4 pulse one clock", 32'(req_rst), 32'h0);
    wait_req(1, 100, n);
    chk("R4 next pulse period", 32'(n), 32'd64);

    // R3: interval 1
    drive(1'b1, 8'h01);
    drive(1'b1, 8'hA5);
    wait_req(0, 300, n);
    chk("R3 interval 1 edges", 32'(n), 32'd256);

    // R11: disabled counter holds, A5 restarts full period
    drive(1'b1, 8'h00);
    drive(1'b1, 8'hDE);
    drive(1'b1, 8'hAD);
    wait_req(0, 300, n);
    chk("R11 no request while off", 32'(req_rst), 32'h0);
    chk("R10 status off", 32'(rd_data), 32'h00);
    drive(1'b1, 8'hA5);
    wait_req(0, 100, n);
    chk("R11 full period after re-enable", 32'(n), 32'd64);

    // R8: lockout write does not restart a running count
    drive(1'b1, 8'hA5);
    for (int i = 0; i < 29; i++) drive(1'b0, 8'h00);
    drive(1'b1, 8'hFF);
    wait_req(30, 100, n);
    chk("R8 lock keeps count", 32'(n), 32'd64);

    // R8: lockout does not enable; R1: reset clears lockout
    do_reset();
    drive(1'b1, 8'hDE);
    drive(1'b1, 8'hAD);
    drive(1'b1, 8'hFF);
    chk("R8 lock leaves watchdog off", 32'(rd_data), 32'h07);
    do_reset();
    drive(1'b1, 8'hDE);
    drive(1'b1, 8'hAD);
    chk("R1 reset clears lockout", 32'(rd_data), 32'h07);

    // R6: lone second key
    drive(1'b1, 8'hA5);
    drive(1'b1, 8'hAD);
    chk("R6 lone second key", 32'(rd_data), 32'h17);

    $display("== %0d vectors applied, %0d miscompares ==", checks, miscompares);
    $finish;
  end

endmodule